// File: doc/BRIEF.md
# Sub-band selection controller

This block sits between a uniform, decimated filter bank and a carrier-tracking loop. It works out which bank output carries the tone and forwards only that output to the loop. A multiplexer does this job, in place of the summing stage a full-band reconstruction would need. The choice follows the loop itself. The tracking frequency estimate is formed by adding the loop filter's correction to the oscillator's nominal frequency. That estimate is then placed among NUM_BANDS equal sub-bands, which start at a programmable lower limit and have a programmable width.

The block is built for banks whose adjacent bands are phase-continuous. Moving from one band to its neighbour therefore puts no phase step into the loop input, and the controller can switch on any decimated sample without a settling step. The band index is found with a row of comparators against the band edges, not with a divider. The index, the forwarded sample and the switch pulse are registered together on each decimated-sample strobe. They appear on the clock edge that follows the strobe.

Top module: `subband_sel`

## Requirements
- R1: The selection estimate is `nominal_freq` (unsigned) plus `loop_corr` (two's complement, sign-extended), computed without wrap-around.
- R2: For an estimate E, `sel_band` becomes the index m for which `band_lo + m*band_step <= E < band_lo + (m+1)*band_step`.
- R3: An estimate below `band_lo`, negative ones included, selects band 0.
- R4: An estimate at or above `band_lo + (NUM_BANDS-1)*band_step` selects band NUM_BANDS-1. This includes estimates beyond the top of the bank, and `sel_band` never exceeds NUM_BANDS-1.
- R5: `sel_band` and `sel_sample` change only on the clock edge after a cycle with `smp_strobe` high. Between strobes, changes to the frequency inputs have no effect on them.
- R6: `sel_valid` is high for exactly the one cycle after each strobe cycle. In that cycle `sel_sample` equals the lane of `band_samples` selected by the new index, where lane k occupies bits `[k*SAMP_W +: SAMP_W]`.
- R7: `band_switch` is high for one cycle, together with `sel_valid`, exactly when the new index differs from the previous one.
- R8: While `rst_n` is low, `sel_band`, `sel_sample`, `sel_valid` and `band_switch` are all zero.
- R9: With five bands, `band_lo` = 176 and `band_step` = 32 (units of 1/1024 rad per sample), an estimate of 303 selects band 3 and an estimate of 304 selects band 4. The 3/4 crossover sits at 0.296875 rad.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| nominal_freq | input | FREQ_W | Oscillator nominal frequency, unsigned |
| loop_corr | input | FREQ_W | Loop filter output, two's complement |
| band_lo | input | FREQ_W | Lower edge of band 0 |
| band_step | input | FREQ_W | Width of each sub-band |
| band_samples | input | NUM_BANDS*SAMP_W | Decimated band outputs, lane k at bits k*SAMP_W |
| smp_strobe | input | 1 | Decimated-sample boundary |
| sel_band | output | IDX_W | Registered selected band index |
| sel_sample | output | SAMP_W | Forwarded sample of the selected band |
| sel_valid | output | 1 | Forwarded sample is valid |
| band_switch | output | 1 | One-cycle pulse when the index changes |

## Verification
The bench places estimates exactly on each band edge and one unit below it. A design that compares with `>` where `>=` belongs would keep the lower band at every edge, including the 303/304 crossover. Further estimates use a negative correction, a negative total and a sum past the top of the bank. A design that truncates the sum or lets the index run past the last band would pick a wrong or nonexistent lane there. Other checks move the frequency inputs between strobes and sweep a ramp across the whole bank. These catch an index that follows the inputs freely, and a switch pulse that fires when the band has not changed or is missed when it has.

// File: rtl/subband_sel_pkg.sv
package subband_sel_pkg;
  localparam int unsigned DEF_BANDS  = 5;
  localparam int unsigned DEF_FREQ_W = 16;
  localparam int unsigned DEF_SAMP_W = 12;

  // index width able to hold 0..n-1, at least one bit
  function automatic int unsigned idx_width(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/subband_freq_sum.sv
module subband_freq_sum #(
  parameter int unsigned FREQ_W = 16,
  parameter int unsigned EW     = 21
) (
  input  logic [FREQ_W-1:0]    nominal_freq,
  input  logic [FREQ_W-1:0]    loop_corr,
  output logic signed [EW-1:0] est
);
  localparam int unsigned PAD = EW - FREQ_W;

  function automatic logic signed [EW-1:0] widen_sum(
    input logic [FREQ_W-1:0] nom, input logic [FREQ_W-1:0] corr);
    logic signed [EW-1:0] a, b;
    a = $signed({{PAD{1'b0}}, nom});
    b = $signed({{PAD{corr[FREQ_W-1]}}, corr});
    return a + b;
  endfunction

  assign est = widen_sum(nominal_freq, loop_corr);
endmodule

// File: rtl/subband_edge_cmp.sv
module subband_edge_cmp #(
  parameter int unsigned NUM_BANDS = 5,
  parameter int unsigned FREQ_W    = 16,
  parameter int unsigned IDX_W     = 3,
  parameter int unsigned EW        = 21
) (
  input  logic signed [EW-1:0] est,
  input  logic [FREQ_W-1:0]    band_lo,
  input  logic [FREQ_W-1:0]    band_step,
  output logic [NUM_BANDS-2:0] above,
  output logic [IDX_W-1:0]     idx
);
  localparam int unsigned NUM_EDGES = NUM_BANDS - 1;
  localparam int unsigned PAD       = EW - FREQ_W;

  // upper edge of band k-1, i.e. lower edge of band k
  function automatic logic signed [EW-1:0] band_edge(
    input logic [FREQ_W-1:0] lo, input logic [FREQ_W-1:0] step, input int unsigned k);
    logic signed [EW-1:0] l, s;
    l = $signed({{PAD{1'b0}}, lo});
    s = $signed({{PAD{1'b0}}, step});
    return l + EW'(k) * s;
  endfunction

  function automatic logic [IDX_W-1:0] count_set(input logic [NUM_EDGES-1:0] v);
    logic [IDX_W-1:0] c;
    c = '0;
    for (int i = 0; i < int'(NUM_EDGES); i++) c = c + IDX_W'(v[i]);
    return c;
  endfunction

  for (genvar k = 1; k < NUM_BANDS; k++) begin : g_edge
    logic signed [EW-1:0] edge_v;
    assign edge_v     = band_edge(band_lo, band_step, k);
    assign above[k-1] = (est >= edge_v);
  end

  assign idx = count_set(above);
endmodule

// File: rtl/subband_select_reg.sv
module subband_select_reg #(
  parameter int unsigned NUM_BANDS = 5,
  parameter int unsigned SAMP_W    = 12,
  parameter int unsigned IDX_W     = 3
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        smp_strobe,
  input  logic [IDX_W-1:0]            next_idx,
  input  logic [NUM_BANDS*SAMP_W-1:0] band_samples,
  output logic [IDX_W-1:0]            sel_band,
  output logic [SAMP_W-1:0]           sel_sample,
  output logic                        sel_valid,
  output logic                        band_switch
);
  logic [SAMP_W-1:0] lane [NUM_BANDS];
  logic [SAMP_W-1:0] picked;
  logic              idx_change;

  for (genvar k = 0; k < NUM_BANDS; k++) begin : g_lane
    assign lane[k] = band_samples[k*SAMP_W +: SAMP_W];
  end

  always_comb begin
    picked = '0;
    for (int k = 0; k < int'(NUM_BANDS); k++)
      if (next_idx == IDX_W'(k)) picked = lane[k];
  end

  assign idx_change = (next_idx != sel_band);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_band    <= '0;
      sel_sample  <= '0;
      sel_valid   <= 1'b0;
      band_switch <= 1'b0;
    end else begin
      sel_valid   <= smp_strobe;
      band_switch <= smp_strobe && idx_change;
      if (smp_strobe) begin
        sel_band   <= next_idx;
        sel_sample <= picked;
      end
    end
  end

  // R5: index only moves after a strobe
  p_idx_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_strobe |=> $stable(sel_band));
  // R6: valid follows the strobe by one cycle
  p_valid_follow_r6: assert property (@(posedge clk) disable iff (!rst_n)
    smp_strobe |=> sel_valid);
  p_valid_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_strobe |=> !sel_valid);
  // R7: pulse marks exactly an index change
  p_switch_change_r7: assert property (@(posedge clk) disable iff (!rst_n)
    sel_valid |-> (band_switch == (sel_band != $past(sel_band))));
  p_switch_valid_r7: assert property (@(posedge clk) disable iff (!rst_n)
    band_switch |-> sel_valid);
  // R4: index stays in range
  p_idx_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
    sel_band <= IDX_W'(NUM_BANDS - 1));
endmodule

// File: rtl/subband_sel.sv
module subband_sel
  import subband_sel_pkg::*;
#(
  parameter int unsigned NUM_BANDS = DEF_BANDS,
  parameter int unsigned FREQ_W    = DEF_FREQ_W,
  parameter int unsigned SAMP_W    = DEF_SAMP_W,
  parameter int unsigned IDX_W     = idx_width(NUM_BANDS)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [FREQ_W-1:0]           nominal_freq,
  input  logic [FREQ_W-1:0]           loop_corr,
  input  logic [FREQ_W-1:0]           band_lo,
  input  logic [FREQ_W-1:0]           band_step,
  input  logic [NUM_BANDS*SAMP_W-1:0] band_samples,
  input  logic                        smp_strobe,
  output logic [IDX_W-1:0]            sel_band,
  output logic [SAMP_W-1:0]           sel_sample,
  output logic                        sel_valid,
  output logic                        band_switch
);
  localparam int unsigned EW        = FREQ_W + IDX_W + 2;
  localparam int unsigned NUM_EDGES = NUM_BANDS - 1;

  logic signed [EW-1:0]  est;
  logic [NUM_EDGES-1:0]  above;
  logic [IDX_W-1:0]      next_idx;
  logic signed [EW-1:0]  lo_ext;

  assign lo_ext = $signed({{(EW-FREQ_W){1'b0}}, band_lo});

  subband_freq_sum #(.FREQ_W(FREQ_W), .EW(EW)) u_sum (
    .nominal_freq (nominal_freq),
    .loop_corr    (loop_corr),
    .est          (est)
  );

  subband_edge_cmp #(.NUM_BANDS(NUM_BANDS), .FREQ_W(FREQ_W), .IDX_W(IDX_W), .EW(EW)) u_cmp (
    .est       (est),
    .band_lo   (band_lo),
    .band_step (band_step),
    .above     (above),
    .idx       (next_idx)
  );

  subband_select_reg #(.NUM_BANDS(NUM_BANDS), .SAMP_W(SAMP_W), .IDX_W(IDX_W)) u_reg (
    .clk          (clk),
    .rst_n        (rst_n),
    .smp_strobe   (smp_strobe),
    .next_idx     (next_idx),
    .band_samples (band_samples),
    .sel_band     (sel_band),
    .sel_sample   (sel_sample),
    .sel_valid    (sel_valid),
    .band_switch  (band_switch)
  );

  // R2: edge comparators form a thermometer (low bits set first)
  p_thermo_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ((above + NUM_EDGES'(1)) & above) == '0);
  // R3: estimate below the bank selects band 0
  p_clamp_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_strobe && (est < lo_ext)) |=> (sel_band == '0));
endmodule

// File: tb/subband_sel_tb.sv
module subband_sel_tb;
  localparam int NB = 5;
  localparam int FW = 16;
  localparam int SW = 12;
  localparam int IW = 3;
  localparam int NV = 13;

  localparam logic [FW-1:0] V_NOM [NV] = '{16'd100, 16'd176, 16'd207, 16'd208, 16'd200,
    16'd300, 16'd272, 16'd303, 16'd304, 16'd335, 16'd336, 16'd65535, 16'd0};
  localparam logic [FW-1:0] V_COR [NV] = '{16'd0, 16'd0, 16'd0, 16'd0, 16'd40,
    16'hFFE3, 16'd0, 16'd0, 16'd0, 16'd0, 16'd0, 16'h7FFF, 16'h8000};
  localparam logic [IW-1:0] V_EXP [NV] = '{3'd0, 3'd0, 3'd0, 3'd1, 3'd2,
    3'd2, 3'd3, 3'd3, 3'd4, 3'd4, 3'd4, 3'd4, 3'd0};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [FW-1:0] nominal_freq = '0, loop_corr = '0, band_lo = 16'd176, band_step = 16'd32;
  logic [NB*SW-1:0] band_samples = '0;
  logic smp_strobe = 1'b0;
  logic [IW-1:0] sel_band;
  logic [SW-1:0] sel_sample;
  logic sel_valid, band_switch;

  int checks = 0, failures = 0;
  logic [IW-1:0] prev_exp = '0;

  always #4 clk = ~clk;

  subband_sel u_dut (
    .clk(clk), .rst_n(rst_n), .nominal_freq(nominal_freq), .loop_corr(loop_corr),
    .band_lo(band_lo), .band_step(band_step), .band_samples(band_samples),
    .smp_strobe(smp_strobe), .sel_band(sel_band), .sel_sample(sel_sample),
    .sel_valid(sel_valid), .band_switch(band_switch)
  );

  function automatic logic [SW-1:0] lane_val(input int base, input int k);
    return SW'(base + k * 17);
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic load_lanes(input int base);
    for (int k = 0; k < NB; k++) band_samples[k*SW +: SW] = lane_val(base, k);
  endtask

  // apply one strobe at a negedge, then check at the following negedge
  task automatic strobe_and_check(input string req, input logic [IW-1:0] exp, input int base);
    smp_strobe = 1'b1;
    @(negedge clk);
    smp_strobe = 1'b0;
    check({req, " band"}, int'(sel_band), int'(exp));
    check({req, " R6 sample"}, int'(sel_sample), int'(lane_val(base, int'(exp))));
    check({req, " R6 valid"}, int'(sel_valid), 1);
    check({req, " R7 switch"}, int'(band_switch), int'(exp != prev_exp));
    prev_exp = exp;
  endtask

  initial begin : watchdog
    #800000;
    failures++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin : main
    int pulses;
    repeat (3) @(negedge clk);
    // R8: reset state
    check("R8 band", int'(sel_band), 0);
    check("R8 sample", int'(sel_sample), 0);
    check("R8 valid", int'(sel_valid), 0);
    check("R8 switch", int'(band_switch), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // table walk: R1 R2 R3 R4 R9
    for (int i = 0; i < NV; i++) begin
      nominal_freq = V_NOM[i];
      loop_corr    = V_COR[i];
      load_lanes(i * 3 + 5);
      strobe_and_check($sformatf("R2 vec%0d", i), V_EXP[i], i * 3 + 5);
    end

    // R9: crossover at 303/304
    nominal_freq = 16'd303; loop_corr = '0; load_lanes(40);
    strobe_and_check("R9 below", 3'd3, 40);
    nominal_freq = 16'd304;
    strobe_and_check("R9 at", 3'd4, 40);

    // R5: inputs move without a strobe, outputs hold
    nominal_freq = 16'd10; load_lanes(90);
    repeat (3) @(negedge clk);
    check("R5 band held", int'(sel_band), 4);
    check("R5 sample held", int'(sel_sample), int'(lane_val(40, 4)));
    check("R6 valid low", int'(sel_valid), 0);
    check("R7 switch low", int'(band_switch), 0);

    // R2: reprogrammed edges 1000 + k*100
    band_lo = 16'd1000; band_step = 16'd100;
    nominal_freq = 16'd1200; loop_corr = 16'd50; load_lanes(7);
    strobe_and_check("R2 prog", 3'd2, 7);
    nominal_freq = 16'd1500; loop_corr = '0;
    strobe_and_check("R4 prog top", 3'd4, 7);
    nominal_freq = 16'd999;
    strobe_and_check("R3 prog low", 3'd0, 7);

    // R7: ramp across default bank, four changes expected
    band_lo = 16'd176; band_step = 16'd32;
    pulses = 0;
    for (int f = 150; f <= 360; f += 8) begin
      logic [IW-1:0] e;
      nominal_freq = FW'(f);
      e = (f < 208) ? 3'd0 : (f < 240) ? 3'd1 : (f < 272) ? 3'd2 : (f < 304) ? 3'd3 : 3'd4;
      smp_strobe = 1'b1;
      @(negedge clk);
      smp_strobe = 1'b0;
      if (band_switch) pulses++;
      check("R7 ramp band", int'(sel_band), int'(e));
      check("R7 ramp switch", int'(band_switch), int'(e != prev_exp));
      prev_exp = e;
      @(negedge clk);
    end
    check("R7 ramp pulse count", pulses, 4);

    // R8: reset mid-run clears outputs
    rst_n = 1'b0;
    @(negedge clk);
    check("R8 band after reset", int'(sel_band), 0);
    check("R8 valid after reset", int'(sel_valid), 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule